// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Unit

This block sits behind a PCIe root port and collects inbound message-signalled interrupt writes. Software programs a 64-bit target address and a 32-bit mask of enabled vectors through a small register port. Each inbound write is presented on a simplified port as a 64-bit address, a 32-bit data word and a valid strobe. When the address equals the programmed target and decoding is switched on, the data word names the vector, and the block sets the pending flag for that vector.

The 32 pending flags drive a single interrupt line that is high while any flag is set. The service routine reads the flag register, handles each pending vector and clears it by writing a one to its bit. Bit 0 of the low target-address register turns address decoding on and off. That bit is not part of the address comparison.

Top module: `msi_capture_unit`

## Requirements
- R1: After reset the flags, the vector-enable mask and both target-address registers read 0, and `irq` is low.
- R2: A write with `msg_valid` high whose address matches and whose vector is enabled sets flag[data[4:0]]. The flag is readable and drives `irq` after the next rising clock edge. One write sets at most one flag.
- R3: Decoding is on only while bit 0 of the low target register (offset 2) is 1. With that bit at 0, including after the register is written with zero, no write sets a flag.
- R4: The address matches only when `msg_addr[31:0]` equals the low target register with bit 0 forced to 0, and `msg_addr[63:32]` equals the high target register (offset 3). On a mismatch in either half, the write is dropped.
- R5: A write whose data is 32 or more is dropped, even when its low five bits name an enabled vector.
- R6: A write whose vector has a 0 in the enable register (offset 1) is dropped. Writing all ones to that register enables every vector.
- R7: Writing to the flag register (offset 0) clears every flag whose bit in the written word is 1 and leaves every other flag unchanged.
- R8: `irq` is high exactly when at least one flag is set.
- R9: When a clear and a set hit the same flag in the same cycle, the flag ends up set.
- R10: With `reg_addr` held, `reg_rdata` shows the addressed register in the same cycle: offset 0 the flags, 1 the enable mask, 2 the low target with bit 0 as written, 3 the high target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 flags, 1 enable, 2 target low, 3 target high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| msg_valid | input | 1 | Inbound interrupt write strobe |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | High while any flag is pending |

## Verification
Every result appears one rising edge after its stimulus, because each path goes through exactly one register stage. Register writes, message captures and flag clears are all visible after that single edge. Read data is combinational, so it is valid in the same cycle that `reg_addr` is applied.

The bench changes inputs on the falling edge and samples `reg_rdata` and `irq` on the next falling edge. At that point exactly one rising edge has passed. Drop cases are judged by reading the flag register after that edge, before any further stimulus.

// File: rtl/msicap_pkg.sv
package msicap_pkg;
  localparam int unsigned VEC_N    = 32;
  localparam int unsigned VEC_W    = $clog2(VEC_N);
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned REG_AW   = 2;

  typedef enum logic [REG_AW-1:0] {
    OFF_FLAGS  = 2'd0,
    OFF_ENABLE = 2'd1,
    OFF_TGT_LO = 2'd2,
    OFF_TGT_HI = 2'd3
  } reg_off_e;

  // True when the data word names a vector that exists.
  function automatic logic vec_in_range(input logic [DATA_W-1:0] d);
    return (d >> VEC_W) == '0;
  endfunction

  // Compare a message address with the programmed target, enable bit masked.
  function automatic logic tgt_match(input logic [ADDR_W-1:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a[31:0] == {lo[31:1], 1'b0}) && (a[63:32] == hi);
  endfunction
endpackage

// File: rtl/msicap_regs.sv
module msicap_regs
  import msicap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_off,
  input  logic [31:0]       wdata,
  output logic [31:0]       tgt_lo,
  output logic [31:0]       tgt_hi,
  output logic [VEC_N-1:0]  vec_en,
  output logic [VEC_N-1:0]  clr_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
      vec_en <= '0;
    end else if (wr_en) begin
      case (reg_off_e'(wr_off))
        OFF_TGT_LO: tgt_lo <= wdata;
        OFF_TGT_HI: tgt_hi <= wdata;
        OFF_ENABLE: vec_en <= wdata[VEC_N-1:0];
        default: ;
      endcase
    end
  end

  assign clr_mask = (wr_en && reg_off_e'(wr_off) == OFF_FLAGS) ? wdata[VEC_N-1:0] : '0;

  a_r3_decode_off_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_off_e'(wr_off) == OFF_TGT_LO && wdata == '0) |=> (tgt_lo[0] == 1'b0));
endmodule

// File: rtl/msicap_decode.sv
module msicap_decode
  import msicap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [31:0]       tgt_lo,
  input  logic [31:0]       tgt_hi,
  input  logic [VEC_N-1:0]  vec_en,
  output logic [VEC_N-1:0]  set_mask
);
  logic             dec_on;
  logic             addr_hit;
  logic             in_range;
  logic [VEC_N-1:0] onehot;

  assign dec_on   = tgt_lo[0];
  assign addr_hit = tgt_match(addr, tgt_lo, tgt_hi);
  assign in_range = vec_in_range(data);

  always_comb begin
    onehot = '0;
    onehot[data[VEC_W-1:0]] = 1'b1;
  end

  assign set_mask = (valid && dec_on && addr_hit && in_range) ? (onehot & vec_en) : '0;

  a_r2_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_mask));
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_lo[0] |-> (set_mask == '0));
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    (data[DATA_W-1:VEC_W] != '0) |-> (set_mask == '0));
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask & ~vec_en) == '0);
endmodule

// File: rtl/msicap_flags.sv
module msicap_flags
  import msicap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_N-1:0] set_mask,
  input  logic [VEC_N-1:0] clr_mask,
  output logic [VEC_N-1:0] flag_q,
  output logic             any_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | set_mask;
  end

  assign any_o = |flag_q;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((flag_q & $past(set_mask)) == $past(set_mask)));
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask != '0) |=> ((flag_q & $past(clr_mask)) == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(flag_q));
endmodule

// File: rtl/msi_capture_unit.sv
module msi_capture_unit
  import msicap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        msg_valid,
  input  logic [63:0] msg_addr,
  input  logic [31:0] msg_data,
  output logic        irq
);
  logic [31:0]      tgt_lo, tgt_hi;
  logic [VEC_N-1:0] vec_en, clr_mask, set_mask, flag_q;
  logic             any_flag;

  msicap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_addr), .wdata(reg_wdata),
    .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .vec_en(vec_en), .clr_mask(clr_mask)
  );

  msicap_decode u_dec (
    .clk(clk), .rst_n(rst_n), .valid(msg_valid), .addr(msg_addr), .data(msg_data),
    .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .vec_en(vec_en), .set_mask(set_mask)
  );

  msicap_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .flag_q(flag_q), .any_o(any_flag)
  );

  always_comb begin
    case (reg_off_e'(reg_addr))
      OFF_FLAGS:  reg_rdata = flag_q;
      OFF_ENABLE: reg_rdata = vec_en;
      OFF_TGT_LO: reg_rdata = tgt_lo;
      default:    reg_rdata = tgt_hi;
    endcase
  end

  assign irq = any_flag;

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> irq);
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (!irq && tgt_lo == '0 && vec_en == '0));
endmodule

// File: tb/msi_capture_unit_tb_top.sv
module msi_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [31:0] LO = 32'h1234_5001;
  localparam logic [31:0] HI = 32'h0000_00AB;
  localparam logic [63:0] HIT = {32'h0000_00AB, 32'h1234_5000};

  always #2 clk = ~clk;

  msi_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: optional register write and optional message, sampled next negedge.
  task automatic cycle(input logic w, input logic [1:0] off, input logic [31:0] wd,
                       input logic mv, input logic [63:0] ma, input logic [31:0] md);
    @(negedge clk);
    reg_wr = w; reg_addr = off; reg_wdata = wd;
    msg_valid = mv; msg_addr = ma; msg_data = md;
    @(negedge clk);
    reg_wr = 1'b0; msg_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] off, output logic [31:0] v);
    reg_addr = off;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] off, input logic [31:0] d);
    cycle(1'b1, off, d, 1'b0, '0, '0);
  endtask

  task automatic msg(input logic [63:0] a, input logic [31:0] d);
    cycle(1'b0, 2'd0, '0, 1'b1, a, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin rd(i[1:0], v); check("R1 reg", v, 0); end
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd2, LO); wr(2'd3, HI);
    rd(2'd1, v); check("R10 enable", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R10 tgt_lo", v, LO);
    rd(2'd3, v); check("R10 tgt_hi", v, HI);
  endtask

  task automatic t_accept();
    logic [31:0] v;
    msg(HIT, 5);
    rd(2'd0, v); check("R2 vec5", v, 32'h20);
    check("R8 irq high", {31'd0, irq}, 1);
    msg(HIT, 31);
    rd(2'd0, v); check("R2 vec31", v, 32'h8000_0020);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(2'd0, 32'h20);       rd(2'd0, v); check("R7 clear bit5", v, 32'h8000_0000);
    wr(2'd0, 32'h0);        rd(2'd0, v); check("R7 write zero", v, 32'h8000_0000);
    wr(2'd0, 32'h8000_0000); rd(2'd0, v); check("R7 clear bit31", v, 0);
    check("R8 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_mismatch();
    logic [31:0] v;
    msg({32'h0000_00AB, 32'h1234_5010}, 2); rd(2'd0, v); check("R4 low differs", v, 0);
    msg({32'h0000_00AC, 32'h1234_5000}, 2); rd(2'd0, v); check("R4 high differs", v, 0);
  endtask

  task automatic t_range();
    logic [31:0] v;
    msg(HIT, 32);    rd(2'd0, v); check("R5 data 32", v, 0);
    msg(HIT, 32'h25); rd(2'd0, v); check("R5 data 0x25", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(2'd1, ~32'h80);
    msg(HIT, 7); rd(2'd0, v); check("R6 disabled vec7", v, 0);
    msg(HIT, 8); rd(2'd0, v); check("R6 enabled vec8", v, 32'h100);
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    msg(HIT, 3); msg(HIT, 4);
    cycle(1'b1, 2'd0, 32'h18, 1'b1, HIT, 3);
    rd(2'd0, v); check("R9 set beats clear", v, 32'h8);
    wr(2'd0, 32'h8); rd(2'd0, v); check("R7 cleanup", v, 0);
  endtask

  task automatic t_decode_off();
    logic [31:0] v;
    wr(2'd2, 32'h1234_5000);
    msg(HIT, 1); rd(2'd0, v); check("R3 bit0 clear", v, 0);
    wr(2'd2, 32'h0);
    msg({32'h0000_00AB, 32'h0}, 1); rd(2'd0, v); check("R3 zero written", v, 0);
    check("R3 irq low", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_accept();
    t_w1c();
    t_mismatch();
    t_range();
    t_mask();
    t_set_wins();
    t_decode_off();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule